// File: doc/BRIEF.md
# DMA Bus-Mode Transfer Sequencer

This block sequences one DMA channel that moves data in dual-address fashion. Each transfer unit is a read cycle at the source address followed by a write cycle at the destination address. The channel takes the system bus through a request/grant handshake with the arbiter. It then steps both addresses by the unit size and counts units down to zero. When the last unit is written, it raises a one-cycle done pulse.

Software arms the channel with four values: a unit count, a source address, a destination address and a unit size (1, 2, 4 or 16 bytes). The same arm also selects one of three bus modes:

- **Burst:** the channel keeps the bus from the first grant until the last unit.
- **Cycle-steal normal:** the channel releases the bus after every unit. It asks for the bus again only while the active-low transfer request is held low.
- **Cycle-steal intermittent:** the channel also releases the bus after every unit, then waits a fixed gap of 16 or 64 clocks before it may request the bus again. This lowers the share of bus time that DMA takes. A transfer request that arrives during the gap is remembered.

Top module: `dma_bus_seq`

## Requirements
- R1: While reset is asserted and after it is released, `breq_o`, `rd_o`, `wr_o`, `busy_o` and `done_o` are low.
- R2: Each unit is exactly one `rd_o` cycle, followed on the next cycle by exactly one `wr_o` cycle. `rd_o` and `wr_o` are never high together.
- R3: The read of unit k (counting from 0) drives `addr_o` = source + k*S, and its write drives `addr_o` = destination + k*S. S is 1, 2, 4 or 16 for `unit_i` = 0, 1, 2 or 3. Addresses wrap modulo 2^AW.
- R4: When the bus is not held, the channel raises `breq_o` only after sampling `dreq_ni` low. A read cycle happens only while both `breq_o` and `bgnt_i` are high.
- R5: In cycle-steal normal mode (`mode_i` = 1), `breq_o` falls after every unit. After a unit, no new request is made while `dreq_ni` stays high.
- R6: In intermittent mode (`mode_i` = 2 for the 16-clock gap, 3 for the 64-clock gap), `breq_o` stays low for at least the gap after each release. If `dreq_ni` was low at any point during the gap, `breq_o` rises exactly when the gap ends, even if `dreq_ni` is high by then.
- R7: In burst mode (`mode_i` = 0), `breq_o` is raised once per transfer and held until the last unit. Units follow each other with a read every second cycle.
- R8: Exactly `count_i` units are moved. `done_o` is high for one cycle, the cycle after the last write, and `breq_o` is low in that cycle.
- R9: After done, `dreq_ni` is ignored and `breq_o` stays low until the channel is armed again.
- R10: An `arm_i` pulse while `busy_o` is high has no effect on the unit count or on the addresses in use.
- R11: Arming with `count_i` = 0 pulses `done_o` in the next cycle without requesting the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Load the settings and start (accepted only when idle) |
| mode_i | input | 2 | 0 burst, 1 cycle-steal normal, 2 intermittent 16, 3 intermittent 64 |
| unit_i | input | 2 | Unit size code: 0 byte, 1 word, 2 longword, 3 16-byte block |
| count_i | input | CW | Number of units to move |
| src_i | input | AW | Source start address |
| dst_i | input | AW | Destination start address |
| dreq_ni | input | 1 | Transfer request, level-sensitive, active low |
| bgnt_i | input | 1 | Bus grant from the arbiter |
| breq_o | output | 1 | Bus request, held for as long as the bus is wanted |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | AW | Address of the current read or write |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse when the last unit has been written |

## Verification
The random transfers hold the request low for the whole transfer, with random arbiter grant latency. This separates the three modes by how many times the bus is requested, and separates the two intermittent gaps by the exact length of each release. One directed test drops the request after the first unit and pulses it once inside an intermittent gap. A second drops it in normal mode. Together they tell a remembered request apart from a request the channel only sees while it is waiting. Count-zero arming, arming while busy, a held-off request and a request held after done complete the corner cases.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    XM_BURST = 2'b00,
    XM_STEAL = 2'b01,
    XM_GAP_S = 2'b10,
    XM_GAP_L = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_GAP,
    S_REQ,
    S_RD,
    S_WR
  } seq_state_e;

  function automatic logic [4:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    unit_bytes = 5'd1;
      2'd1:    unit_bytes = 5'd2;
      2'd2:    unit_bytes = 5'd4;
      default: unit_bytes = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [1:0]    unit_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          last_o
);
  localparam int NPTR = 2;

  logic [1:0]    unit_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] stride;
  logic [AW-1:0] ptr_q  [NPTR];
  logic [AW-1:0] ptr_ld [NPTR];

  assign stride    = AW'(unit_bytes(unit_q));
  assign ptr_ld[0] = src_i;
  assign ptr_ld[1] = dst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      unit_q <= unit_i;
      cnt_q  <= cnt_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ptr_q[g] <= '0;
      else if (load_i)  ptr_q[g] <= ptr_ld[g];
      else if (step_i)  ptr_q[g] <= ptr_q[g] + stride;
    end
  end

  assign src_o  = ptr_q[0];
  assign dst_o  = ptr_q[1];
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  input  logic dreq_i,
  output logic expired_o,
  output logic pending_o
);
  localparam int GMAX = (GAP_LONG > GAP_SHORT) ? GAP_LONG : GAP_SHORT;
  localparam int TW   = $clog2(GMAX + 1);

  logic [TW-1:0] cnt_q;
  logic          run_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= long_i ? TW'(GAP_LONG - 1) : TW'(GAP_SHORT - 1);
      run_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - TW'(1);
      if (dreq_i)      pend_q <= 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
  assign pending_o = pend_q;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic [1:0] mode_i,
  input  logic       count_zero_i,
  input  logic       dreq_i,
  input  logic       bgnt_i,
  input  logic       last_i,
  input  logic       gap_exp_i,
  input  logic       gap_pend_i,
  output logic       load_o,
  output logic       step_o,
  output logic       gap_start_o,
  output logic       gap_long_o,
  output logic       breq_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       busy_o,
  output logic       done_o
);
  seq_state_e st_q, st_d;
  xfer_mode_e mode_q;
  logic       done_q, done_d;

  always_comb begin
    st_d        = st_q;
    load_o      = 1'b0;
    step_o      = 1'b0;
    gap_start_o = 1'b0;
    done_d      = 1'b0;
    case (st_q)
      S_IDLE: if (arm_i) begin
        if (count_zero_i) done_d = 1'b1;
        else begin
          load_o = 1'b1;
          st_d   = S_WAIT;
        end
      end
      S_WAIT: if (dreq_i) st_d = S_REQ;
      S_GAP:  if (gap_exp_i) st_d = (gap_pend_i || dreq_i) ? S_REQ : S_WAIT;
      S_REQ:  if (bgnt_i) st_d = S_RD;
      S_RD:   st_d = S_WR;
      S_WR: begin
        step_o = 1'b1;
        if (last_i) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
        end else begin
          case (mode_q)
            XM_BURST: st_d = S_RD;
            XM_STEAL: st_d = S_WAIT;
            default: begin
              st_d        = S_GAP;
              gap_start_o = 1'b1;
            end
          endcase
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      mode_q <= XM_BURST;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (load_o) mode_q <= xfer_mode_e'(mode_i);
    end
  end

  assign gap_long_o = (mode_q == XM_GAP_L);
  assign breq_o     = (st_q == S_REQ) || (st_q == S_RD) || (st_q == S_WR);
  assign rd_o       = (st_q == S_RD);
  assign wr_o       = (st_q == S_WR);
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    unit_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          dreq_ni,
  input  logic          bgnt_i,
  output logic          breq_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          dreq_act;
  logic          load, step, last;
  logic          gap_start, gap_long, gap_exp, gap_pend;
  logic [AW-1:0] src_cur, dst_cur;

  assign dreq_act = ~dreq_ni;

  dma_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .mode_i       (mode_i),
    .count_zero_i (count_i == '0),
    .dreq_i       (dreq_act),
    .bgnt_i       (bgnt_i),
    .last_i       (last),
    .gap_exp_i    (gap_exp),
    .gap_pend_i   (gap_pend),
    .load_o       (load),
    .step_o       (step),
    .gap_start_o  (gap_start),
    .gap_long_o   (gap_long),
    .breq_o       (breq_o),
    .rd_o         (rd_o),
    .wr_o         (wr_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  dma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .unit_i (unit_i),
    .src_i  (src_i),
    .dst_i  (dst_i),
    .cnt_i  (count_i),
    .src_o  (src_cur),
    .dst_o  (dst_cur),
    .last_o (last)
  );

  dma_gap_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (gap_start),
    .long_i    (gap_long),
    .dreq_i    (dreq_act),
    .expired_o (gap_exp),
    .pending_o (gap_pend)
  );

  assign addr_o = wr_o ? dst_cur : src_cur;
endmodule

// File: rtl/dma_bus_seq_chk.sv
module dma_bus_seq_chk #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arm_i,
  input logic [1:0] mode_i,
  input logic       bgnt_i,
  input logic       breq_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic       busy_o,
  input logic       done_o
);
  localparam int LW = $clog2(GAP_LONG + 2);

  logic [1:0]    mode_q;
  logic          rel_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 2'd0;
      rel_q  <= 1'b0;
      low_q  <= '0;
    end else begin
      if (arm_i && !busy_o) begin
        mode_q <= mode_i;
        rel_q  <= 1'b0;
      end else if (!breq_o && low_q == '0 && busy_o) begin
        rel_q  <= 1'b1;
      end
      if (breq_o)                      low_q <= '0;
      else if (low_q != {LW{1'b1}})    low_q <= low_q + LW'(1);
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R2
  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(rd_o)); // R2
  AST_RD_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (bgnt_i && breq_o)); // R4
  AST_GAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(breq_o) && rel_q && mode_q[1])
      |-> (low_q >= (mode_q[0] ? LW'(GAP_LONG) : LW'(GAP_SHORT)))); // R6
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(breq_o) && mode_q == 2'd0 && !arm_i) |-> done_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !breq_o); // R8
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !breq_o); // R9
endmodule

bind dma_bus_seq dma_bus_seq_chk #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .arm_i  (arm_i),
  .mode_i (mode_i),
  .bgnt_i (bgnt_i),
  .breq_o (breq_o),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/tb_dma_bus_seq.sv
module tb_dma_bus_seq;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int GS = 16;
  localparam int GL = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          arm_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [1:0]    unit_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [AW-1:0] src_i = '0;
  logic [AW-1:0] dst_i = '0;
  logic          dreq_ni = 1'b1;
  logic          bgnt_i = 1'b0;
  logic          breq_o, rd_o, wr_o, busy_o, done_o;
  logic [AW-1:0] addr_o;

  always #2 clk_i = ~clk_i;

  dma_bus_seq #(.AW(AW), .CW(CW), .GAP_SHORT(GS), .GAP_LONG(GL)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .mode_i(mode_i), .unit_i(unit_i),
    .count_i(count_i), .src_i(src_i), .dst_i(dst_i), .dreq_ni(dreq_ni), .bgnt_i(bgnt_i),
    .breq_o(breq_o), .rd_o(rd_o), .wr_o(wr_o), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int sz_of(input logic [1:0] u);
    return 1 << ((u == 2'd3) ? 4 : int'(u));
  endfunction

  function automatic int gap_of(input logic [1:0] m);
    return m[0] ? GL : GS;
  endfunction

  // arbiter model with random grant latency
  int gnt_wait = 0;
  always @(negedge clk_i) begin
    if (!breq_o) begin
      bgnt_i   <= 1'b0;
      gnt_wait = $urandom % 4;
    end else if (!bgnt_i) begin
      if (gnt_wait == 0) bgnt_i <= 1'b1;
      else gnt_wait--;
    end
  end

  // bus monitor
  bit            mon_en = 0;
  logic [AW-1:0] e_src, e_dst;
  int            e_sz;
  int m_units, m_rises, m_min_low, m_max_low, m_low_run;
  int m_addr_err, m_proto_err, m_rd_space, m_max_rd_space, m_done_cnt, m_done_bad;
  bit m_prev_rd, m_prev_wr, m_prev_breq, m_released;

  task automatic mon_clear();
    m_units = 0; m_rises = 0; m_min_low = 1000000; m_max_low = 0; m_low_run = 0;
    m_addr_err = 0; m_proto_err = 0; m_rd_space = 0; m_max_rd_space = 0;
    m_done_cnt = 0; m_done_bad = 0;
    m_prev_rd = 0; m_prev_wr = 0; m_prev_breq = 0; m_released = 0;
  endtask

  always @(negedge clk_i) begin
    if (mon_en) begin
      logic [AW-1:0] ea;
      m_rd_space++;
      if (rd_o) begin
        if (!bgnt_i || wr_o) m_proto_err++;
        ea = e_src + AW'(m_units * e_sz);
        if (addr_o != ea) m_addr_err++;
        if (m_units > 0 && m_rd_space > m_max_rd_space) m_max_rd_space = m_rd_space;
        m_rd_space = 0;
      end
      if (wr_o) begin
        if (!m_prev_rd) m_proto_err++;
        ea = e_dst + AW'(m_units * e_sz);
        if (addr_o != ea) m_addr_err++;
        m_units++;
      end
      if (breq_o && !m_prev_breq) begin
        m_rises++;
        if (m_released) begin
          if (m_low_run < m_min_low) m_min_low = m_low_run;
          if (m_low_run > m_max_low) m_max_low = m_low_run;
        end
      end
      if (!breq_o && m_prev_breq) m_released = 1;
      if (breq_o) m_low_run = 0; else m_low_run++;
      if (done_o) begin
        m_done_cnt++;
        if (!m_prev_wr || breq_o) m_done_bad++;
      end
      m_prev_rd = rd_o; m_prev_wr = wr_o; m_prev_breq = breq_o;
    end
  end

  task automatic arm(input logic [1:0] m, input logic [1:0] u, input int c,
                     input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk_i);
    mode_i = m; unit_i = u; count_i = CW'(c); src_i = s; dst_i = d; arm_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
  endtask

  task automatic start_xfer(input logic [1:0] m, input logic [1:0] u, input int c,
                            input logic [AW-1:0] s, input logic [AW-1:0] d);
    mon_clear();
    e_src = s; e_dst = d; e_sz = sz_of(u);
    mon_en = 1;
    arm(m, u, c, s, d);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done_o && k < 20000) begin
      @(negedge clk_i);
      k++;
    end
    @(negedge clk_i);
    mon_en = 0;
  endtask

  task automatic eval_xfer(input logic [1:0] m, input int c);
    int hits = 0;
    chk(m_units == c, "R8 units", m_units, c);
    chk(m_done_cnt == 1 && m_done_bad == 0, "R8 done pulse", m_done_cnt + 10 * m_done_bad, 1);
    chk(m_addr_err == 0, "R3 addresses", m_addr_err, 0);
    chk(m_proto_err == 0, "R2/R4 strobes", m_proto_err, 0);
    if (m == 2'd0) begin
      chk(m_rises == 1, "R7 one request", m_rises, 1);
      if (c > 1) chk(m_max_rd_space == 2, "R7 back to back", m_max_rd_space, 2);
    end else begin
      chk(m_rises == c, "R5 request per unit", m_rises, c);
      if (m[1] && c > 1)
        chk(m_min_low == gap_of(m) && m_max_low == gap_of(m), "R6 gap",
            m_min_low, gap_of(m));
    end
    // R9: request held low after done is ignored
    dreq_ni = 1'b0;
    repeat (20) begin
      @(negedge clk_i);
      if (breq_o) hits++;
    end
    dreq_ni = 1'b1;
    chk(hits == 0, "R9 no request after done", hits, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    fork
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    // R1 reset
    repeat (3) @(negedge clk_i);
    chk({breq_o, rd_o, wr_o, busy_o, done_o} == 5'b0, "R1 in reset",
        {breq_o, rd_o, wr_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({breq_o, rd_o, wr_o, busy_o, done_o} == 5'b0, "R1 after reset",
        {breq_o, rd_o, wr_o, busy_o, done_o}, 0);

    // R11 zero count
    arm(2'd1, 2'd0, 0, 32'h100, 32'h200);
    chk(done_o && !breq_o && !busy_o, "R11 done at once", {done_o, breq_o, busy_o}, 3'b100);
    @(negedge clk_i);
    chk(!done_o, "R11 single pulse", done_o, 0);

    // R4 request held off until dreq low
    start_xfer(2'd1, 2'd2, 1, 32'h1000, 32'h2000);
    repeat (10) @(negedge clk_i);
    chk(!breq_o && busy_o, "R4 no request without dreq", breq_o, 0);
    dreq_ni = 1'b0;
    wait_done();
    dreq_ni = 1'b1;
    eval_xfer(2'd1, 1);

    // R5 normal mode: no request after unit while dreq high
    start_xfer(2'd1, 2'd1, 2, 32'h3000, 32'h4000);
    dreq_ni = 1'b0;
    while (!wr_o) @(negedge clk_i);
    dreq_ni = 1'b1;
    begin
      int hits = 0;
      repeat (30) begin
        @(negedge clk_i);
        if (breq_o) hits++;
      end
      chk(hits == 0 && busy_o, "R5 waits for dreq", hits, 0);
    end
    dreq_ni = 1'b0;
    wait_done();
    dreq_ni = 1'b1;
    eval_xfer(2'd1, 2);

    // R6 pending request remembered across the gap
    start_xfer(2'd2, 2'd1, 2, 32'h5000, 32'h6000);
    dreq_ni = 1'b0;
    while (!wr_o) @(negedge clk_i);
    dreq_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    dreq_ni = 1'b0;
    @(negedge clk_i);
    dreq_ni = 1'b1;
    wait_done();
    eval_xfer(2'd2, 2);

    // R10 arm while busy ignored
    start_xfer(2'd1, 2'd0, 3, 32'h7000, 32'h8000);
    dreq_ni = 1'b0;
    while (!rd_o) @(negedge clk_i);
    count_i = CW'(9); src_i = 32'hdead_0000; dst_i = 32'hbeef_0000; mode_i = 2'd0;
    arm_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
    wait_done();
    dreq_ni = 1'b1;
    chk(m_units == 3 && m_addr_err == 0, "R10 arm ignored", m_units, 3);
    eval_xfer(2'd1, 3);

    // wrapping address, 16-byte units, long gap
    start_xfer(2'd3, 2'd3, 3, 32'hffff_ffe0, 32'h0000_0010);
    dreq_ni = 1'b0;
    wait_done();
    dreq_ni = 1'b1;
    eval_xfer(2'd3, 3);

    // constrained random transfers
    for (int t = 0; t < 24; t++) begin
      logic [1:0] m = 2'($urandom % 4);
      logic [1:0] u = 2'($urandom % 4);
      int c = 1 + int'($urandom % 6);
      logic [AW-1:0] s = $urandom;
      logic [AW-1:0] d = $urandom;
      start_xfer(m, u, c, s, d);
      repeat ($urandom % 5) @(negedge clk_i);
      dreq_ni = 1'b0;
      wait_done();
      dreq_ni = 1'b1;
      eval_xfer(m, c);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule